// File: doc/BRIEF.md
# Indexed Register Window Bridge

This block sits between a host port and a small set of internal units. It lets the host reach all of them through one short address range. The host first stores a selector code in an index register. After that, each access to a sixteen-byte data window goes to the unit that the selector names. The block also passes on the low offset bits, so the unit knows which of its locations is meant.

There are five possible targets:

- transfer channel A
- transfer channel B
- the byte queue of the line-signalling controller
- the lower bank of that controller's byte registers
- the upper bank of that controller's byte registers

In this design the internal units are plain storage stubs. This makes the decoded traffic visible and keeps the block testable on its own.

Host software reaches a logical signalling register in two steps. It first picks the bank from the register's logical offset. It then uses the low four bits of that offset as the byte position in the window. The index register keeps its value until the host rewrites it. Any number of window accesses can therefore follow one selection.

Top module: `idx_window_bridge`

## Requirements
- R1: After reset the index register holds 0x00, so channel A is selected, and every stub location reads as zero.
- R2: A write to host offset 0x04 loads host_wdata[7:0] into the index register. A read of offset 0x04 returns that byte zero-extended to 32 bits.
- R3: During a window access (host offsets 0x10 to 0x1F), tgt_sel reports the target chosen by the stored index. The index-to-code mapping is:
  - index 0x00 gives code 1 (channel A)
  - index 0x01 gives code 2 (channel B)
  - index 0x02 gives code 3 (signalling queue)
  - index 0x04 gives code 4 (lower bank)
  - index 0x06 gives code 5 (upper bank)
  - any other index gives code 0
- R4: With a channel selected, window byte 0x0 is that channel's 32-bit data port and window byte 0x4 is its 32-bit control/status word. Each is written and read back independently per channel.
- R5: With the signalling queue selected, successive writes to window byte 0x0 enqueue host_wdata[7:0]. Successive reads there return the bytes in write order, zero-extended. Each read advances the queue by one.
- R6: With a bank selected, window byte n (0 to 15) is byte register n of that bank. The lower and upper banks are separate storage.
- R7: A logical signalling register offset above 0x2F is reached through index 0x06, and any other logical offset through index 0x04. In both cases the window byte is offset[3:0].
- R8: The following reads return 0xFFFFFFFF:
  - any host offset other than 0x04 and the window
  - window bytes other than 0x0 and 0x4 under a channel index
  - window bytes other than 0x0 under the queue index
  - any window byte under an undefined index

  Writes to these locations change nothing, and reads of them do not advance the queue.
- R9: The index remains in force for every later window access until it is rewritten.
- R10: During a window access tgt_off equals host_addr[3:0]. With no access in progress, tgt_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 5 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the cycle of host_rd |
| tgt_sel | output | 3 | Decoded target code for the current window access |
| tgt_off | output | 4 | Local byte offset handed to the target |

## Verification
Directed sequences cover the following cases:

- Each target is written and read back. This separates the two channels from each other, and the two banks from each other.
- Three bytes are streamed through the queue. This shows ordering and one advance per read.
- Logical offsets on both sides of 0x2F are used. This confirms the bank split.
- Undefined indexes, offsets outside the window, and holes in the window are accessed, each followed by a read-back. This shows they touch no state and do not advance the queue.

A seeded random mix of index changes, window accesses and stray offsets is then checked against a bench model. It exposes any case where a stale or wrongly decoded index steers an access to the wrong unit.

// File: rtl/iwb_pkg.sv
package iwb_pkg;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_CHA   = 3'd1,
    TGT_CHB   = 3'd2,
    TGT_SQ    = 3'd3,
    TGT_LOW   = 3'd4,
    TGT_HIGH  = 3'd5
  } tgt_e;

  localparam logic [7:0] SEL_CHA  = 8'h00;
  localparam logic [7:0] SEL_CHB  = 8'h01;
  localparam logic [7:0] SEL_SQ   = 8'h02;
  localparam logic [7:0] SEL_LOW  = 8'h04;
  localparam logic [7:0] SEL_HIGH = 8'h06;

  // Map a stored selector code onto a target.
  function automatic tgt_e sel_to_tgt(input logic [7:0] sel);
    case (sel)
      SEL_CHA:  return TGT_CHA;
      SEL_CHB:  return TGT_CHB;
      SEL_SQ:   return TGT_SQ;
      SEL_LOW:  return TGT_LOW;
      SEL_HIGH: return TGT_HIGH;
      default:  return TGT_NONE;
    endcase
  endfunction

  // Selector that host software uses for a logical signalling register.
  function automatic logic [7:0] bank_sel_for(input logic [7:0] loff);
    return (loff > 8'h2F) ? SEL_HIGH : SEL_LOW;
  endfunction

endpackage

// File: rtl/iwb_decode.sv
module iwb_decode
  import iwb_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic             acc,
  input  logic             win,
  input  logic [7:0]       sel,
  input  logic [OFF_W-1:0] off,
  output tgt_e             tgt,
  output logic             loc_ok
);

  always_comb begin
    tgt    = TGT_NONE;
    loc_ok = 1'b0;
    if (acc && win) begin
      tgt = sel_to_tgt(sel);
      case (tgt)
        TGT_CHA, TGT_CHB: loc_ok = (off == OFF_W'(0)) || (off == OFF_W'(4));
        TGT_SQ:           loc_ok = (off == OFF_W'(0));
        TGT_LOW, TGT_HIGH: loc_ok = 1'b1;
        default:          loc_ok = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/iwb_stubs.sv
module iwb_chan_stub #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_port,
  input  logic          wr_ctl,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] port_q,
  output logic [DW-1:0] ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (wr_port) port_q <= din;
      if (wr_ctl)  ctl_q  <= din;
    end
  end
endmodule

module iwb_byte_queue #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic [PW-1:0] rptr
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) begin
        mem[wptr] <= din;
        wptr      <= wptr + 1'b1;
      end
      if (pop) rptr <= rptr + 1'b1;
    end
  end

  assign dout = mem[rptr];
endmodule

module iwb_byte_bank #(
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout
);
  logic [7:0] regs [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we) begin
      regs[addr] <= din;
    end
  end

  assign dout = regs[addr];
endmodule

// File: rtl/idx_window_bridge.sv
module idx_window_bridge
  import iwb_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int IDX_OFF  = 4,
  parameter int WIN_BASE = 16,
  parameter int WIN_BYTES = 16,
  parameter int SQ_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [2:0]        tgt_sel,
  output logic [$clog2(WIN_BYTES)-1:0] tgt_off
);

  localparam int OFF_W = $clog2(WIN_BYTES);
  localparam int PW    = $clog2(SQ_DEPTH);
  localparam int NCH   = 2;

  // Named internal events.
  logic             acc, idx_hit, win_hit, idx_load, loc_ok;
  logic             sq_push, sq_pop;
  logic [OFF_W-1:0] win_off;
  logic [7:0]       idx_q;
  tgt_e             tgt;
  logic [4:0]       tgt_en;
  logic [PW-1:0]    sq_rptr;
  logic [7:0]       sq_dout, low_dout, high_dout;
  logic [DATA_W-1:0] ch_port [NCH];
  logic [DATA_W-1:0] ch_ctl  [NCH];

  assign acc      = host_rd | host_wr;
  assign idx_hit  = (int'(host_addr) == IDX_OFF);
  assign win_hit  = (int'(host_addr) >= WIN_BASE) && (int'(host_addr) < WIN_BASE + WIN_BYTES);
  assign win_off  = host_addr[OFF_W-1:0];
  assign idx_load = host_wr & idx_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= SEL_CHA;
    else if (idx_load) idx_q <= host_wdata[7:0];
  end

  iwb_decode #(.OFF_W(OFF_W)) u_dec (
    .acc(acc), .win(win_hit), .sel(idx_q), .off(win_off),
    .tgt(tgt), .loc_ok(loc_ok)
  );

  assign tgt_sel = tgt;
  assign tgt_off = win_off;
  assign tgt_en  = {loc_ok && tgt == TGT_HIGH, loc_ok && tgt == TGT_LOW,
                    loc_ok && tgt == TGT_SQ, loc_ok && tgt == TGT_CHB,
                    loc_ok && tgt == TGT_CHA};

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      iwb_chan_stub #(.DW(DATA_W)) u_ch (
        .clk(clk), .rst_n(rst_n),
        .wr_port(host_wr && tgt_en[c] && win_off == OFF_W'(0)),
        .wr_ctl (host_wr && tgt_en[c] && win_off == OFF_W'(4)),
        .din(host_wdata), .port_q(ch_port[c]), .ctl_q(ch_ctl[c])
      );
    end
  endgenerate

  assign sq_push = host_wr & tgt_en[2];
  assign sq_pop  = host_rd & tgt_en[2];

  iwb_byte_queue #(.DEPTH(SQ_DEPTH)) u_sq (
    .clk(clk), .rst_n(rst_n), .push(sq_push), .pop(sq_pop),
    .din(host_wdata[7:0]), .dout(sq_dout), .rptr(sq_rptr)
  );

  iwb_byte_bank #(.N(WIN_BYTES)) u_low (
    .clk(clk), .rst_n(rst_n), .we(host_wr & tgt_en[3]), .addr(win_off),
    .din(host_wdata[7:0]), .dout(low_dout)
  );

  iwb_byte_bank #(.N(WIN_BYTES)) u_high (
    .clk(clk), .rst_n(rst_n), .we(host_wr & tgt_en[4]), .addr(win_off),
    .din(host_wdata[7:0]), .dout(high_dout)
  );

  always_comb begin
    host_rdata = '1;
    if (idx_hit) begin
      host_rdata = DATA_W'(idx_q);
    end else if (loc_ok) begin
      case (tgt)
        TGT_CHA:  host_rdata = (win_off == OFF_W'(0)) ? ch_port[0] : ch_ctl[0];
        TGT_CHB:  host_rdata = (win_off == OFF_W'(0)) ? ch_port[1] : ch_ctl[1];
        TGT_SQ:   host_rdata = DATA_W'(sq_dout);
        TGT_LOW:  host_rdata = DATA_W'(low_dout);
        TGT_HIGH: host_rdata = DATA_W'(high_dout);
        default:  host_rdata = '1;
      endcase
    end
  end

endmodule

// File: rtl/iwb_checker.sv
module iwb_checker #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int IDX_OFF  = 4,
  parameter int WIN_BASE = 16,
  parameter int PW       = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic [7:0]        idx_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic [2:0]        tgt_sel,
  input logic [7:0]        idx_q,
  input logic              idx_load,
  input logic              sq_pop,
  input logic [PW-1:0]     sq_rptr,
  input logic [4:0]        tgt_en
);

  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> idx_q == $past(idx_wdata));

  p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_load |=> $stable(idx_q));

  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_en));

  p_idle_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd || host_wr) |-> tgt_sel == 3'd0);

  p_stray_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && int'(host_addr) < WIN_BASE && int'(host_addr) != IDX_OFF) |-> (&host_rdata));

  p_queue_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sq_pop |=> sq_rptr == PW'($past(sq_rptr) + 1'b1));

endmodule

bind idx_window_bridge iwb_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_OFF(IDX_OFF), .WIN_BASE(WIN_BASE), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .idx_wdata(host_wdata[7:0]), .host_rdata(host_rdata),
  .tgt_sel(tgt_sel), .idx_q(idx_q), .idx_load(idx_load), .sq_pop(sq_pop),
  .sq_rptr(sq_rptr), .tgt_en(tgt_en)
);

// File: tb/tb_idx_window_bridge.sv
module tb_idx_window_bridge;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [2:0]  tgt_sel;
  logic [3:0]  tgt_off;

  int total = 0, bad = 0;

  idx_window_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tgt_sel(tgt_sel), .tgt_off(tgt_off)
  );

  always #(PERIOD/2) clk = ~clk;

  // Bench model of the visible state.
  logic [7:0]  m_idx;
  logic [31:0] m_port [2];
  logic [31:0] m_ctl  [2];
  logic [7:0]  m_sq   [8];
  logic [2:0]  m_wp, m_rp;
  logic [7:0]  m_low  [16];
  logic [7:0]  m_high [16];

  task automatic model_reset();
    m_idx = 8'h00; m_wp = '0; m_rp = '0;
    for (int i = 0; i < 2; i++) begin m_port[i] = '0; m_ctl[i] = '0; end
    for (int i = 0; i < 8; i++) m_sq[i] = '0;
    for (int i = 0; i < 16; i++) begin m_low[i] = '0; m_high[i] = '0; end
  endtask

  function automatic logic [2:0] exp_code(input logic [4:0] a);
    if (a < 5'h10) return 3'd0;
    case (m_idx)
      8'h00: return 3'd1;
      8'h01: return 3'd2;
      8'h02: return 3'd3;
      8'h04: return 3'd4;
      8'h06: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    logic [3:0] o;
    o = a[3:0];
    if (a == 5'h04) return {24'h0, m_idx};
    if (a < 5'h10) return '1;
    case (m_idx)
      8'h00, 8'h01: begin
        if (o == 4'h0) return m_port[m_idx[0]];
        if (o == 4'h4) return m_ctl[m_idx[0]];
        return '1;
      end
      8'h02:   return (o == 4'h0) ? {24'h0, m_sq[m_rp]} : '1;
      8'h04:   return {24'h0, m_low[o]};
      8'h06:   return {24'h0, m_high[o]};
      default: return '1;
    endcase
  endfunction

  function automatic logic [7:0] sel_for_logical(input logic [7:0] loff);
    if (loff >= 8'h30) return 8'h06;
    return 8'h04;
  endfunction

  task automatic model_wr(input logic [4:0] a, input logic [31:0] d);
    logic [3:0] o;
    o = a[3:0];
    if (a == 5'h04) m_idx = d[7:0];
    else if (a >= 5'h10) begin
      case (m_idx)
        8'h00, 8'h01: begin
          if (o == 4'h0) m_port[m_idx[0]] = d;
          if (o == 4'h4) m_ctl[m_idx[0]] = d;
        end
        8'h02: if (o == 4'h0) begin m_sq[m_wp] = d[7:0]; m_wp = m_wp + 1'b1; end
        8'h04: m_low[o] = d[7:0];
        8'h06: m_high[o] = d[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_decode(input logic [4:0] a, input logic [2:0] sel, input logic [3:0] off);
    check(sel == exp_code(a), "R3 tgt_sel", 32'(sel), 32'(exp_code(a)));
    if (a >= 5'h10) check(off == a[3:0], "R10 tgt_off", 32'(off), 32'(a[3:0]));
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [2:0] s; logic [3:0] o;
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    #(PERIOD/4);
    s = tgt_sel; o = tgt_off;
    @(negedge clk);
    host_wr = 1'b0;
    check_decode(a, s, o);
    model_wr(a, d);
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    logic [31:0] v, e; logic [2:0] s; logic [3:0] o;
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #(PERIOD/4);
    v = host_rdata; s = tgt_sel; o = tgt_off;
    e = exp_rd(a);
    @(negedge clk);
    host_rd = 1'b0;
    check(v === e, tag, v, e);
    check_decode(a, s, o);
    if (a >= 5'h10 && m_idx == 8'h02 && a[3:0] == 4'h0) m_rp = m_rp + 1'b1;
  endtask

  task automatic reg_wr(input logic [7:0] loff, input logic [7:0] val);
    wr(5'h04, {24'h0, sel_for_logical(loff)});
    wr(5'h10 + {1'b0, loff[3:0]}, {24'h0, val});
  endtask

  task automatic reg_rd(input logic [7:0] loff);
    wr(5'h04, {24'h0, sel_for_logical(loff)});
    rd(5'h10 + {1'b0, loff[3:0]}, "R7 logical register");
  endtask

  initial begin
    #(PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd2024);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(5'h04, "R1 index after reset");
    rd(5'h10, "R1 channel A port after reset");
    rd(5'h14, "R1 channel A ctl after reset");

    // R10: idle cycle shows no target
    @(negedge clk); #(PERIOD/4);
    check(tgt_sel == 3'd0, "R10 idle tgt_sel", 32'(tgt_sel), 32'h0);

    // R2: index read-back of arbitrary byte
    wr(5'h04, 32'hDEAD_BE5A);
    rd(5'h04, "R2 index readback");

    // R4: channels independent
    wr(5'h04, 32'h01);
    wr(5'h10, 32'hA1A2_A3A4);
    wr(5'h14, 32'h0000_C0DE);
    wr(5'h04, 32'h00);
    wr(5'h10, 32'h1234_5678);
    rd(5'h10, "R4 channel A port");
    rd(5'h14, "R4 channel A ctl untouched");
    wr(5'h04, 32'h01);
    rd(5'h10, "R4 channel B port");
    rd(5'h14, "R4 channel B ctl");
    rd(5'h18, "R8 channel hole");

    // R5: queue ordering, holes do not advance
    wr(5'h04, 32'h02);
    wr(5'h10, 32'h11);
    wr(5'h10, 32'h22);
    wr(5'h10, 32'h33);
    rd(5'h10, "R5 queue first");
    rd(5'h11, "R8 queue hole");
    rd(5'h10, "R5 queue second");
    rd(5'h10, "R5 queue third");

    // R6/R7: logical offsets on both sides of 0x2F
    reg_wr(8'h25, 8'h5A);
    reg_wr(8'h35, 8'hA5);
    reg_wr(8'h2F, 8'h77);
    reg_wr(8'h30, 8'h88);
    reg_rd(8'h25);
    reg_rd(8'h35);
    reg_rd(8'h2F);
    reg_rd(8'h30);
    wr(5'h04, 32'h04);
    rd(5'h10, "R6 lower bank byte 0");

    // R8: undefined index ignores writes
    wr(5'h04, 32'h03);
    wr(5'h15, 32'hFF);
    rd(5'h15, "R8 undefined index read");
    wr(5'h04, 32'h04);
    rd(5'h15, "R8 lower bank unchanged");
    wr(5'h04, 32'h06);
    rd(5'h15, "R8 upper bank unchanged");
    // R8: stray host offsets
    wr(5'h08, 32'h0000_0002);
    rd(5'h04, "R8 stray write left index");
    rd(5'h08, "R8 stray read");
    rd(5'h00, "R8 stray read low");

    // R9: index persists across several accesses
    wr(5'h04, 32'h04);
    wr(5'h13, 32'h3C);
    rd(5'h13, "R9 persist one");
    wr(5'h1F, 32'hC3);
    rd(5'h1F, "R9 persist two");
    rd(5'h04, "R9 index still lower bank");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int kind;
      logic [4:0] a;
      kind = int'($urandom_range(0, 9));
      if (kind < 2) begin
        logic [7:0] pick [7];
        pick = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h06, 8'h03, 8'h05};
        wr(5'h04, {24'h0, pick[$urandom_range(0, 6)]});
      end else if (kind < 5) begin
        a = 5'h10 + 5'($urandom_range(0, 15));
        wr(a, $urandom);
      end else if (kind < 8) begin
        a = 5'h10 + 5'($urandom_range(0, 15));
        rd(a, "R9 random window read");
      end else if (kind == 8) begin
        rd(5'h04, "R2 random index read");
      end else begin
        a = 5'($urandom_range(0, 15));
        if (a == 5'h04) a = 5'h0C;
        rd(a, "R8 random stray read");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule